// File: doc/BRIEF.md
# Dual-Port Collision Monitor with Busy Address Register

This block sits beside a true dual-port memory and watches both access ports. Each port presents a valid strobe, a write enable and an address every cycle. If both ports touch the same location in the same cycle, the block decides which port's data is at risk and raises a registered busy flag to that port only. It also flags a reader's data as invalid, or tells the reader whether it sees the newly written word. The decision uses two per-cycle inputs: an ordering bit, which says which port was first, and an unresolved-ordering bit.

The first conflicting address after arming is latched into a busy address register, which has a full bit. Later matches still raise busy but leave the register untouched. Either port may issue a readback command. The stored address and its full bit then come back on that port's readback outputs a fixed number of cycles later. A readback re-arms the register, but capture is held off for a short window so that a match close to the command is not stored.

Top module: `dp_collide_mon`

## Requirements
- R1: A match is both valid strobes high with equal addresses. Every flag output is registered: it reflects the cycle before, it is low in any cycle after a cycle with no match, and at most one busy flag is high at a time.
- R2: A match where neither port writes raises no busy, no invalid and no new-data flag, and stores no address: a later readback shows full = 0.
- R3: A match where both ports write raises busy on the losing port only. With the default setting WW_WIN_A = 1, port A wins and b_busy goes high.
- R4: A match with one writer and one reader while order_unres = 1 raises busy and the invalid flag on the reading port. Neither flag is raised on the writing port.
- R5: A match with one writer and one reader while order_unres = 0 raises no busy. The reader's new-data flag goes high when the reader was ordered first: order_b_first = 0 means A first, and 1 means B first.
- R6: After reset all flag and readback outputs are 0, the register is empty (full = 0), and capture is armed.
- R7: While armed, a match involving at least one write stores its address (from port A), sets full and disarms capture. Later matches do not change the stored value.
- R8: A readback request on a port makes that port's rdy high exactly RB_LAT = 2 cycles later, together with the address and full bit the register held in the request cycle. In all other cycles rdy, addr and full read 0, and the other port is unaffected.
- R9: A readback re-arms capture but discards matches in the request cycle and the following cycle (RB_GAP = 2). The first write-involving match two or more cycles after the request is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_vld | input | 1 | Port A access valid |
| a_we | input | 1 | Port A write enable |
| a_addr | input | AW | Port A address |
| b_vld | input | 1 | Port B access valid |
| b_we | input | 1 | Port B write enable |
| b_addr | input | AW | Port B address |
| order_b_first | input | 1 | 1 when port B's access is ordered first |
| order_unres | input | 1 | 1 when the ordering of the two accesses is unresolved |
| a_rb_req | input | 1 | Readback command on port A |
| b_rb_req | input | 1 | Readback command on port B |
| a_busy | output | 1 | Busy to port A |
| b_busy | output | 1 | Busy to port B |
| a_rd_bad | output | 1 | Port A read data invalid |
| b_rd_bad | output | 1 | Port B read data invalid |
| a_rd_new | output | 1 | Port A read returns newly written data |
| b_rd_new | output | 1 | Port B read returns newly written data |
| a_rb_rdy | output | 1 | Readback result valid on port A |
| a_rb_addr | output | AW | Stored address returned to port A |
| a_rb_full | output | 1 | Stored full bit returned to port A |
| b_rb_rdy | output | 1 | Readback result valid on port B |
| b_rb_addr | output | AW | Stored address returned to port B |
| b_rb_full | output | 1 | Stored full bit returned to port B |

## Verification
A wrong classification shows up on the busy, invalid or new-data flags one cycle after the colliding access. A lockout or arming fault in the busy register shows nothing at once. It becomes visible only at the next readback, two cycles after the command, as a wrong address or full bit. For that reason the sweep issues readbacks often, and directed sequences place matches in the request cycle, the cycle after it and two cycles after it.

// File: rtl/dpcol_pkg.sv
package dpcol_pkg;

   // per-cycle classification of the two port accesses
   typedef struct packed {
      logic busy_a;
      logic busy_b;
      logic bad_a;
      logic bad_b;
      logic new_a;
      logic new_b;
      logic conflict;
   } col_t;

endpackage

// File: rtl/dpcol_classify.sv
module dpcol_classify
   import dpcol_pkg::*;
#(
   parameter int AW       = 17,
   parameter bit WW_WIN_A = 1'b1
) (
   input  logic          a_vld,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic          b_vld,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic          order_b_first,
   input  logic          order_unres,
   output col_t          res
);

   logic hit, both_wr, one_wr, a_reads, b_reads;
   logic lose_a, lose_b;

   assign hit     = a_vld & b_vld & (a_addr == b_addr);
   assign both_wr = hit & a_we & b_we;
   assign one_wr  = hit & (a_we ^ b_we);
   assign a_reads = one_wr & b_we;
   assign b_reads = one_wr & a_we;

   generate
      if (WW_WIN_A) begin : g_win_a
         assign lose_a = 1'b0;
         assign lose_b = both_wr;
      end else begin : g_win_b
         assign lose_a = both_wr;
         assign lose_b = 1'b0;
      end
   endgenerate

   always_comb begin
      res.busy_a   = lose_a | (a_reads & order_unres);
      res.busy_b   = lose_b | (b_reads & order_unres);
      res.bad_a    = a_reads & order_unres;
      res.bad_b    = b_reads & order_unres;
      res.new_a    = a_reads & ~order_unres & ~order_b_first;
      res.new_b    = b_reads & ~order_unres &  order_b_first;
      res.conflict = both_wr | one_wr;
   end

endmodule

// File: rtl/dpcol_busy_reg.sv
module dpcol_busy_reg #(
   parameter int AW     = 17,
   parameter int RB_GAP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          conflict,
   input  logic [AW-1:0] hit_addr,
   input  logic          rb_any,
   output logic [AW-1:0] st_addr,
   output logic          st_full
);

   localparam int CW = $clog2(RB_GAP + 1);
   localparam logic [CW-1:0] GAP_LD = CW'(RB_GAP - 1);

   logic          arm_q;
   logic [CW-1:0] gap_q;
   logic          take;

   assign take = arm_q & (gap_q == '0) & conflict & ~rb_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q   <= 1'b1;
         gap_q   <= '0;
         st_addr <= '0;
         st_full <= 1'b0;
      end else begin
         if (rb_any) begin
            arm_q <= 1'b1;
            gap_q <= GAP_LD;
         end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
         end
         if (take) begin
            arm_q   <= 1'b0;
            st_addr <= hit_addr;
            st_full <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dpcol_rb_pipe.sv
module dpcol_rb_pipe #(
   parameter int AW  = 17,
   parameter int LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [AW-1:0] st_addr,
   input  logic          st_full,
   output logic          rdy,
   output logic [AW-1:0] addr,
   output logic          full
);

   logic [LAT-1:0]         rdy_s;
   logic [LAT-1:0]         full_s;
   logic [LAT-1:0][AW-1:0] addr_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_s  <= '0;
         full_s <= '0;
         addr_s <= '0;
      end else begin
         rdy_s[0]  <= req;
         full_s[0] <= req & st_full;
         addr_s[0] <= req ? st_addr : '0;
         for (int i = 1; i < LAT; i++) begin
            rdy_s[i]  <= rdy_s[i-1];
            full_s[i] <= full_s[i-1];
            addr_s[i] <= addr_s[i-1];
         end
      end
   end

   assign rdy  = rdy_s[LAT-1];
   assign full = full_s[LAT-1];
   assign addr = addr_s[LAT-1];

endmodule

// File: rtl/dp_collide_mon.sv
module dp_collide_mon
   import dpcol_pkg::*;
#(
   parameter int AW       = 17,
   parameter int RB_LAT   = 2,
   parameter int RB_GAP   = 2,
   parameter bit WW_WIN_A = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_vld,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic          b_vld,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic          order_b_first,
   input  logic          order_unres,
   input  logic          a_rb_req,
   input  logic          b_rb_req,
   output logic          a_busy,
   output logic          b_busy,
   output logic          a_rd_bad,
   output logic          b_rd_bad,
   output logic          a_rd_new,
   output logic          b_rd_new,
   output logic          a_rb_rdy,
   output logic [AW-1:0] a_rb_addr,
   output logic          a_rb_full,
   output logic          b_rb_rdy,
   output logic [AW-1:0] b_rb_addr,
   output logic          b_rb_full
);

   localparam int NPORT = 2;

   generate
      if (AW < 1) begin : g_bad_aw
         $error("dp_collide_mon: AW must be at least 1");
      end
      if (RB_LAT < 1) begin : g_bad_lat
         $error("dp_collide_mon: RB_LAT must be at least 1");
      end
      if (RB_GAP < 1) begin : g_bad_gap
         $error("dp_collide_mon: RB_GAP must be at least 1");
      end
   endgenerate

   col_t          cls;
   logic [AW-1:0] st_addr;
   logic          st_full;

   dpcol_classify #(.AW(AW), .WW_WIN_A(WW_WIN_A)) cls_i (
      .a_vld(a_vld), .a_we(a_we), .a_addr(a_addr),
      .b_vld(b_vld), .b_we(b_we), .b_addr(b_addr),
      .order_b_first(order_b_first), .order_unres(order_unres),
      .res(cls)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_busy   <= 1'b0;
         b_busy   <= 1'b0;
         a_rd_bad <= 1'b0;
         b_rd_bad <= 1'b0;
         a_rd_new <= 1'b0;
         b_rd_new <= 1'b0;
      end else begin
         a_busy   <= cls.busy_a;
         b_busy   <= cls.busy_b;
         a_rd_bad <= cls.bad_a;
         b_rd_bad <= cls.bad_b;
         a_rd_new <= cls.new_a;
         b_rd_new <= cls.new_b;
      end
   end

   dpcol_busy_reg #(.AW(AW), .RB_GAP(RB_GAP)) breg_i (
      .clk(clk), .rst_n(rst_n),
      .conflict(cls.conflict), .hit_addr(a_addr),
      .rb_any(a_rb_req | b_rb_req),
      .st_addr(st_addr), .st_full(st_full)
   );

   logic [NPORT-1:0]         rq_v, rdy_v, full_v;
   logic [NPORT-1:0][AW-1:0] addr_v;

   assign rq_v = {b_rb_req, a_rb_req};

   generate
      for (genvar g = 0; g < NPORT; g++) begin : g_port
         dpcol_rb_pipe #(.AW(AW), .LAT(RB_LAT)) pipe_i (
            .clk(clk), .rst_n(rst_n), .req(rq_v[g]),
            .st_addr(st_addr), .st_full(st_full),
            .rdy(rdy_v[g]), .addr(addr_v[g]), .full(full_v[g])
         );
      end
   endgenerate

   assign a_rb_rdy  = rdy_v[0];
   assign a_rb_addr = addr_v[0];
   assign a_rb_full = full_v[0];
   assign b_rb_rdy  = rdy_v[1];
   assign b_rb_addr = addr_v[1];
   assign b_rb_full = full_v[1];

endmodule

// File: rtl/dpcol_chk.sv
module dpcol_chk #(
   parameter int AW       = 17,
   parameter int RB_LAT   = 2,
   parameter bit WW_WIN_A = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          a_vld,
   input logic          a_we,
   input logic [AW-1:0] a_addr,
   input logic          b_vld,
   input logic          b_we,
   input logic [AW-1:0] b_addr,
   input logic          order_unres,
   input logic          a_rb_req,
   input logic          b_rb_req,
   input logic          a_busy,
   input logic          b_busy,
   input logic          a_rd_bad,
   input logic          b_rd_bad,
   input logic          a_rd_new,
   input logic          b_rd_new,
   input logic          a_rb_rdy,
   input logic [AW-1:0] a_rb_addr,
   input logic          b_rb_rdy,
   input logic [AW-1:0] b_rb_addr
);

   logic same;
   assign same = a_vld & b_vld & (a_addr == b_addr);

   logic [RB_LAT-1:0] sh_a, sh_b;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_a <= '0;
         sh_b <= '0;
      end else begin
         sh_a <= {sh_a[RB_LAT-2:0], a_rb_req};
         sh_b <= {sh_b[RB_LAT-2:0], b_rb_req};
      end
   end

   // R1
   no_match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !same |=> (!a_busy && !b_busy && !a_rd_new && !b_rd_new));

   // R1
   busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({a_busy, b_busy}));

   // R2
   read_pair_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (same && !a_we && !b_we) |=> (!a_busy && !b_busy && !a_rd_bad && !b_rd_bad));

   // R3
   write_pair_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (same && a_we && b_we) |=> (WW_WIN_A ? (b_busy && !a_busy) : (a_busy && !b_busy)));

   // R4
   bad_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd_bad || b_rd_bad) |-> ((a_rd_bad == a_busy) && (b_rd_bad == b_busy)));

   // R5
   ordered_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (same && (a_we ^ b_we) && !order_unres) |=> (!a_busy && !b_busy));

   // R8
   rb_latency_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_rb_rdy == sh_a[RB_LAT-1]);

   // R8
   rb_latency_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_rb_rdy == sh_b[RB_LAT-1]);

   // R8
   rb_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_rb_rdy |-> a_rb_addr == '0) and (!b_rb_rdy |-> b_rb_addr == '0));

endmodule

bind dp_collide_mon dpcol_chk #(.AW(AW), .RB_LAT(RB_LAT), .WW_WIN_A(WW_WIN_A)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .a_vld(a_vld), .a_we(a_we), .a_addr(a_addr),
   .b_vld(b_vld), .b_we(b_we), .b_addr(b_addr),
   .order_unres(order_unres),
   .a_rb_req(a_rb_req), .b_rb_req(b_rb_req),
   .a_busy(a_busy), .b_busy(b_busy),
   .a_rd_bad(a_rd_bad), .b_rd_bad(b_rd_bad),
   .a_rd_new(a_rd_new), .b_rd_new(b_rd_new),
   .a_rb_rdy(a_rb_rdy), .a_rb_addr(a_rb_addr),
   .b_rb_rdy(b_rb_rdy), .b_rb_addr(b_rb_addr)
);

// File: tb/dp_collide_mon_tb_top.sv
module dp_collide_mon_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_vld = 0, a_we = 0, b_vld = 0, b_we = 0;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic order_b_first = 0, order_unres = 0, a_rb_req = 0, b_rb_req = 0;
   logic a_busy, b_busy, a_rd_bad, b_rd_bad, a_rd_new, b_rd_new;
   logic a_rb_rdy, a_rb_full, b_rb_rdy, b_rb_full;
   logic [AW-1:0] a_rb_addr, b_rb_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   dp_collide_mon #(.AW(AW)) dut_i (.*);

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // bench model state
   bit m_arm = 1, m_full = 0;
   int m_gap = 0, m_addr = 0;
   bit s_ra = 0, s_rb = 0, s_full = 0;
   int s_addr = 0;
   string rb_tag = "R6";

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(bit av, bit awe, int aa, bit bv, bit bwe, int ba,
                       bit ord, bit vio, bit ra, bit rb);
      bit m, conf, cap;
      bit eba, ebb, ebda, ebdb, ena, enb;
      bit xra, xrb, xf;
      int xa;
      string t;
      a_vld = av; a_we = awe; a_addr = AW'(aa);
      b_vld = bv; b_we = bwe; b_addr = AW'(ba);
      order_b_first = ord; order_unres = vio;
      a_rb_req = ra; b_rb_req = rb;
      m    = av && bv && (aa == ba);
      conf = m && (awe || bwe);
      eba  = m && !awe && bwe && vio;
      ebb  = m && ((awe && bwe) || (awe && !bwe && vio));
      ebda = m && !awe && bwe && vio;
      ebdb = m && awe && !bwe && vio;
      ena  = m && !awe && bwe && !vio && !ord;
      enb  = m && awe && !bwe && !vio && ord;
      if (!m) t = "R1";
      else if (!awe && !bwe) t = "R2";
      else if (awe && bwe) t = "R3";
      else if (vio) t = "R4";
      else t = "R5";
      // readback expectation comes from the request one step earlier
      xra = s_ra; xrb = s_rb; xf = s_full; xa = s_addr;
      s_ra = ra; s_rb = rb; s_full = m_full; s_addr = m_addr;
      cap = m_arm && (m_gap == 0) && conf && !(ra || rb);
      if (ra || rb) begin m_arm = 1; m_gap = 1; end
      else if (m_gap != 0) m_gap--;
      if (cap) begin m_arm = 0; m_full = 1; m_addr = aa; end
      @(posedge clk);
      @(negedge clk);
      chk(t, "a_busy", a_busy, eba);
      chk(t, "b_busy", b_busy, ebb);
      chk(t, "a_rd_bad", a_rd_bad, ebda);
      chk(t, "b_rd_bad", b_rd_bad, ebdb);
      chk(t, "a_rd_new", a_rd_new, ena);
      chk(t, "b_rd_new", b_rd_new, enb);
      chk(rb_tag, "a_rb_rdy", a_rb_rdy, xra);
      chk(rb_tag, "b_rb_rdy", b_rb_rdy, xrb);
      chk(rb_tag, "a_rb_full", a_rb_full, xra & xf);
      chk(rb_tag, "b_rb_full", b_rb_full, xrb & xf);
      chk(rb_tag, "a_rb_addr", a_rb_addr, xra ? xa : 0);
      chk(rb_tag, "b_rb_addr", b_rb_addr, xrb ? xa : 0);
   endtask

   task automatic idle(bit ra, bit rb);
      step(0, 0, 0, 0, 0, 0, 0, 0, ra, rb);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R6: outputs clear after reset, register empty
      chk("R6", "reset a_busy", a_busy, 0);
      chk("R6", "reset b_busy", b_busy, 0);
      chk("R6", "reset a_rb_rdy", a_rb_rdy, 0);
      idle(1, 0);
      idle(0, 0);
      idle(0, 0);
      // R2: read pair at same address stores nothing
      rb_tag = "R2";
      step(1, 0, 5, 1, 0, 5, 0, 0, 0, 0);
      idle(0, 0);
      idle(0, 1);
      idle(0, 0);
      idle(0, 0);
      // R7: first conflict stored, second ignored
      rb_tag = "R7";
      step(1, 1, 3, 1, 1, 3, 0, 0, 0, 0);
      step(1, 1, 9, 1, 0, 9, 1, 1, 0, 0);
      idle(1, 0);
      idle(0, 0);
      // R9: matches in request cycle and next are dropped, third kept
      rb_tag = "R9";
      step(1, 1, 1, 1, 1, 1, 0, 0, 1, 0);
      step(1, 0, 2, 1, 1, 2, 0, 1, 0, 0);
      step(1, 1, 4, 1, 0, 4, 1, 0, 0, 0);
      step(1, 1, 6, 1, 1, 6, 0, 0, 0, 0);
      idle(0, 1);
      idle(1, 1);
      idle(0, 0);
      // R8 and full sweep over addresses, write enables and ordering
      rb_tag = "R8/R7/R9";
      begin
         int k = 0;
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               for (int w = 0; w < 4; w++)
                  for (int o = 0; o < 4; o++) begin
                     k++;
                     step((k % 7) != 3, w[0], a, (k % 11) != 5, w[1], b,
                          o[0], o[1], (k % 23) == 0, (k % 31) == 0);
                  end
      end
      idle(0, 0);
      idle(0, 0);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule